// File: doc/BRIEF.md
# Double-Buffered Color Conversion Matrix

This block converts each pixel of a three-channel stream (RGB or YCbCr) with a 3x4 affine matrix. For each output channel it adds three weighted input channels and one constant offset. It then rounds the result to the nearest integer and clamps it to the unsigned pixel range. Coefficients are 16-bit signed fixed-point numbers with 13 fractional bits, so 0x2000 stands for a gain of 1.0.

Two coefficient banks, A and B, hold complete matrices. A host write port loads coefficients, and each write always lands in the bank that is not driving the pixels. Software writes a selection (bypass, A or B) into a pending register. The block adopts that selection only on the first pixel of the next frame, so a frame is never converted with two different matrices. A readback output reports the selection in force, which tells software which bank is free to program. Pixels arrive as a valid-qualified stream with a frame-start flag and leave three clock cycles later.

Top module: `ccm_pingpong`

## Requirements
- R1: During and after a synchronous active-high reset, `out_valid` is 0 and `active_mode` is 0 (bypass). The pending selection also resets to bypass, so a frame started without any mode write passes through unchanged.
- R2: While the selection in force is 0 (bypass), each output pixel equals the input pixel bit for bit.
- R3: Every accepted pixel appears on the outputs exactly 3 clock cycles after the edge that sampled it. `out_valid` and `out_sof` follow `in_valid` and `in_valid && in_sof` with the same delay, and `out_valid` is 0 for cycles with no input.
- R4: For output channel r, the block forms acc = sum over k of C[r][k]*x_k plus (O_r << PIX_W). The coefficients are signed 16-bit, the inputs x_k are unsigned, and the result is floor((acc + 4096) / 8192).
- R5: A result below 0 is output as 0, and a result above 2^PIX_W - 1 is output as 2^PIX_W - 1.
- R6: A bank that holds 0x2000 on the diagonal and 0 in every other term reproduces the input exactly.
- R7: Coefficient writes use `cfg_addr` 0 to 5. Word k carries coefficient index 2k in bits [15:0] and index 2k+1 in bits [31:16]. Coefficient index = row*4 + term, where term 3 is the offset O. Row r drives output channel r, which sits at pixel bits [r*PIX_W +: PIX_W], as do the input channels.
- R8: A coefficient write goes to bank B when the selection in force is A, and to bank A otherwise (B or bypass). Such writes never change pixels converted by the bank in force.
- R9: Writing `cfg_addr` 7 loads `cfg_wdata[1:0]` into the pending selection: 0 means bypass, 1 means bank A, 2 means bank B. The value 3 is ignored and leaves the pending selection unchanged. `active_mode` never reads 3.
- R10: The pending selection takes effect at the first pixel with `in_valid && in_sof`, and that pixel already uses it. `active_mode` shows the new value from the cycle after that pixel. Mode writes made in the middle of a frame change neither the output nor `active_mode` before the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Host write strobe |
| cfg_addr | input | 3 | Host word address: 0-5 coefficient pairs, 7 mode |
| cfg_wdata | input | 2*COEF_W | Host write data |
| active_mode | output | 2 | Selection in force: 0 bypass, 1 bank A, 2 bank B |
| in_valid | input | 1 | Input pixel valid |
| in_sof | input | 1 | First pixel of a frame (qualified by in_valid) |
| in_pix | input | 3*PIX_W | Input pixel, channel r at bits [r*PIX_W +: PIX_W] |
| out_valid | output | 1 | Output pixel valid |
| out_sof | output | 1 | Output frame start |
| out_pix | output | 3*PIX_W | Converted pixel, same channel layout |

## Verification
Each pixel result is due on the third rising edge after the edge that sampled the input. `active_mode` changes one edge after the frame-start pixel is accepted. The bench drives inputs and samples outputs on falling edges. It keeps a three-deep queue of expected values, computed when each pixel is driven, and compares the oldest entry with the ports, so every comparison falls in the cycle the result is due. Host writes are issued only in cycles without a pixel. This makes the bank contents seen by every pixel unambiguous in both the reference model and the design.

// File: rtl/ccm_pkg.sv
package ccm_pkg;
  localparam int NUM_IN    = 3;              // input channels per pixel
  localparam int NUM_ROWS  = 3;              // output channels
  localparam int NUM_TERMS = NUM_IN + 1;     // three gains plus offset
  localparam int NUM_COEF  = NUM_ROWS * NUM_TERMS;
  localparam int NUM_PAIRS = NUM_COEF / 2;   // two coefficients per host word

  typedef enum logic [1:0] {
    SEL_BYP = 2'd0,
    SEL_A   = 2'd1,
    SEL_B   = 2'd2
  } sel_e;
endpackage

// File: rtl/ccm_mode_ctrl.sv
module ccm_mode_ctrl (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_we,
  input  logic [1:0]    mode_val,
  input  logic          frame_go,
  output ccm_pkg::sel_e active,
  output ccm_pkg::sel_e eff_sel
);
  import ccm_pkg::*;

  sel_e pending;

  // The frame-start pixel already uses the pending choice.
  assign eff_sel = frame_go ? pending : active;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= SEL_BYP;
      active  <= SEL_BYP;
    end else begin
      if (mode_we && (mode_val != 2'd3))
        pending <= sel_e'(mode_val);
      if (frame_go)
        active <= pending;
    end
  end
endmodule

// File: rtl/ccm_coef_bank.sv
module ccm_coef_bank #(
  parameter int COEF_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic                                            clk,
  input  logic                                            rst,
  input  logic                                            wr_en,
  input  logic [ADDR_W-1:0]                               wr_pair,
  input  logic [2*COEF_W-1:0]                             wr_data,
  input  ccm_pkg::sel_e                                   active,
  input  ccm_pkg::sel_e                                   rd_sel,
  output logic [ccm_pkg::NUM_COEF-1:0][COEF_W-1:0]        coef
);
  import ccm_pkg::*;

  localparam int IDX_W = $clog2(NUM_COEF);

  logic [NUM_COEF-1:0][COEF_W-1:0] bank_a;
  logic [NUM_COEF-1:0][COEF_W-1:0] bank_b;
  logic [IDX_W-1:0] lo_idx;
  logic [IDX_W-1:0] hi_idx;
  logic             to_b;

  assign lo_idx = IDX_W'({wr_pair, 1'b0});
  assign hi_idx = lo_idx | IDX_W'(1);
  // Writes always go to the bank not in force.
  assign to_b   = (active == SEL_A);

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_a <= '0;
      bank_b <= '0;
    end else if (wr_en) begin
      if (to_b) begin
        bank_b[lo_idx] <= wr_data[COEF_W-1:0];
        bank_b[hi_idx] <= wr_data[2*COEF_W-1:COEF_W];
      end else begin
        bank_a[lo_idx] <= wr_data[COEF_W-1:0];
        bank_a[hi_idx] <= wr_data[2*COEF_W-1:COEF_W];
      end
    end
  end

  assign coef = (rd_sel == SEL_B) ? bank_b : bank_a;
endmodule

// File: rtl/ccm_row.sv
module ccm_row #(
  parameter int PIX_W  = 10,
  parameter int COEF_W = 16,
  parameter int FRAC   = 13
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic [ccm_pkg::NUM_IN-1:0][PIX_W-1:0]         x,
  input  logic [ccm_pkg::NUM_TERMS-1:0][COEF_W-1:0]     c,
  input  logic                                          byp,
  input  logic [PIX_W-1:0]                              raw,
  output logic [PIX_W-1:0]                              y
);
  import ccm_pkg::*;

  localparam int PROD_W = COEF_W + PIX_W + 1;
  localparam int ACC_W  = PROD_W + 2;
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(2 ** (FRAC - 1));
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((2 ** PIX_W) - 1);

  logic signed [PROD_W-1:0] prod_q [NUM_TERMS];
  logic                     byp_q;
  logic [PIX_W-1:0]         raw_q;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  rnd;
  logic signed [ACC_W-1:0]  shf;
  logic [PIX_W-1:0]         sat_v;

  // Stage 2: products and scaled offset.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_TERMS; k++) prod_q[k] <= '0;
      byp_q <= 1'b0;
      raw_q <= '0;
    end else begin
      for (int k = 0; k < NUM_IN; k++)
        prod_q[k] <= $signed(c[k]) * $signed({1'b0, x[k]});
      prod_q[NUM_IN] <= $signed({c[NUM_IN][COEF_W-1], c[NUM_IN], {PIX_W{1'b0}}});
      byp_q <= byp;
      raw_q <= raw;
    end
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NUM_TERMS; k++) acc = acc + ACC_W'(prod_q[k]);
    rnd = acc + HALF;
    shf = rnd >>> FRAC;
    if (shf < 0)         sat_v = '0;
    else if (shf > MAXV) sat_v = MAXV[PIX_W-1:0];
    else                 sat_v = shf[PIX_W-1:0];
  end

  // Stage 3: registered result.
  always_ff @(posedge clk) begin
    if (rst) y <= '0;
    else     y <= byp_q ? raw_q : sat_v;
  end
endmodule

// File: rtl/ccm_pingpong.sv
module ccm_pingpong #(
  parameter int PIX_W  = 10,
  parameter int COEF_W = 16,
  parameter int FRAC   = 13
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [2:0]            cfg_addr,
  input  logic [2*COEF_W-1:0]   cfg_wdata,
  output logic [1:0]            active_mode,
  input  logic                  in_valid,
  input  logic                  in_sof,
  input  logic [3*PIX_W-1:0]    in_pix,
  output logic                  out_valid,
  output logic                  out_sof,
  output logic [3*PIX_W-1:0]    out_pix
);
  import ccm_pkg::*;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'((2 ** ADDR_W) - 1);
  localparam logic [ADDR_W-1:0] PAIR_LIM  = ADDR_W'(NUM_PAIRS);

  logic wr_coef;
  logic mode_we;
  logic frame_go;
  sel_e active;
  sel_e eff_sel;

  logic                          s1_valid, s1_sof;
  logic [NUM_IN-1:0][PIX_W-1:0]  s1_pix;
  sel_e                          s1_sel;
  logic                          s2_valid, s2_sof;
  logic                          v3, f3;

  logic [NUM_COEF-1:0][COEF_W-1:0] coef;
  logic [NUM_ROWS-1:0][PIX_W-1:0]  row_y;

  assign wr_coef  = cfg_we && (cfg_addr < PAIR_LIM);
  assign mode_we  = cfg_we && (cfg_addr == MODE_ADDR);
  assign frame_go = in_valid && in_sof;

  ccm_mode_ctrl u_mode (
    .clk      (clk),
    .rst      (rst),
    .mode_we  (mode_we),
    .mode_val (cfg_wdata[1:0]),
    .frame_go (frame_go),
    .active   (active),
    .eff_sel  (eff_sel)
  );

  ccm_coef_bank #(.COEF_W(COEF_W), .ADDR_W(ADDR_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_coef),
    .wr_pair (cfg_addr),
    .wr_data (cfg_wdata),
    .active  (active),
    .rd_sel  (s1_sel),
    .coef    (coef)
  );

  // Stage 1: input capture with the selection bound to the pixel.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_sof   <= 1'b0;
      s1_pix   <= '0;
      s1_sel   <= SEL_BYP;
      s2_valid <= 1'b0;
      s2_sof   <= 1'b0;
      v3       <= 1'b0;
      f3       <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      s1_sof   <= frame_go;
      s1_pix   <= in_pix;
      s1_sel   <= eff_sel;
      s2_valid <= s1_valid;
      s2_sof   <= s1_sof;
      v3       <= s2_valid;
      f3       <= s2_sof;
    end
  end

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    ccm_row #(.PIX_W(PIX_W), .COEF_W(COEF_W), .FRAC(FRAC)) u_row (
      .clk (clk),
      .rst (rst),
      .x   (s1_pix),
      .c   (coef[r*NUM_TERMS +: NUM_TERMS]),
      .byp (s1_sel == SEL_BYP),
      .raw (s1_pix[r]),
      .y   (row_y[r])
    );
  end

  assign out_valid   = v3;
  assign out_sof     = f3;
  assign out_pix     = row_y;
  assign active_mode = active;
endmodule

// File: rtl/ccm_pingpong_chk.sv
module ccm_pingpong_chk #(
  parameter int PIX_W = 10
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_sof,
  input logic [3*PIX_W-1:0] in_pix,
  input logic               out_valid,
  input logic               out_sof,
  input logic [3*PIX_W-1:0] out_pix,
  input logic [1:0]         active_mode
);
  logic [1:0] cyc;

  always_ff @(posedge clk) begin
    if (rst)            cyc <= '0;
    else if (cyc != 3)  cyc <= cyc + 2'd1;
  end

  // R3: valid follows input by three cycles
  a_r3_latency: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R3: frame start travels with its pixel
  a_r3_sof_delay: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd3) |-> (out_sof == $past(in_valid && in_sof, 3)));

  // R2: bypass reproduces the input
  a_r2_bypass: assert property (@(posedge clk) disable iff (rst)
    ((cyc == 2'd3) && $past(in_valid, 3) && !$past(in_sof, 3) &&
     ($past(active_mode, 3) == 2'd0)) |-> (out_pix == $past(in_pix, 3)));

  // R10: selection changes only after an accepted frame start
  a_r10_swap_at_sof: assert property (@(posedge clk) disable iff (rst)
    ((cyc != 2'd0) && (active_mode != $past(active_mode))) |->
      $past(in_valid && in_sof));

  // R9: the reserved code never becomes active
  a_r9_legal_mode: assert property (@(posedge clk) disable iff (rst)
    active_mode != 2'd3);
endmodule

bind ccm_pingpong ccm_pingpong_chk #(.PIX_W(PIX_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_sof      (in_sof),
  .in_pix      (in_pix),
  .out_valid   (out_valid),
  .out_sof     (out_sof),
  .out_pix     (out_pix),
  .active_mode (active_mode)
);

// File: tb/ccm_pingpong_test.sv
module ccm_pingpong_test;
  localparam int PIX_W = 10;
  localparam int PW    = 3 * PIX_W;
  localparam int MAXP  = (1 << PIX_W) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [1:0]    active_mode;
  logic          in_valid = 1'b0;
  logic          in_sof = 1'b0;
  logic [PW-1:0] in_pix = '0;
  logic          out_valid;
  logic          out_sof;
  logic [PW-1:0] out_pix;

  always #10 clk = ~clk;

  ccm_pingpong #(.PIX_W(PIX_W)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .active_mode(active_mode),
    .in_valid(in_valid), .in_sof(in_sof), .in_pix(in_pix),
    .out_valid(out_valid), .out_sof(out_sof), .out_pix(out_pix)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference state
  int          m_act = 0;
  int          m_pend = 0;
  logic [15:0] mb [2][12];

  // expected-result queue, index 1 newest, 3 due now
  bit          q_v [1:3];
  bit          q_s [1:3];
  logic [PW-1:0] q_p [1:3];
  string       q_t [1:3];

  function automatic logic [PIX_W-1:0] calc(logic [PW-1:0] p, int b, int r);
    longint acc;
    acc = longint'($signed(mb[b][r*4+3])) * (longint'(1) << PIX_W);
    for (int k = 0; k < 3; k++)
      acc += longint'($signed(mb[b][r*4+k])) * longint'(p[k*PIX_W +: PIX_W]);
    acc = (acc + 4096) >>> 13;
    if (acc < 0) return '0;
    if (acc > MAXP) return PIX_W'(MAXP);
    return acc[PIX_W-1:0];
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic check_out();
    n_chk++;
    if (out_valid !== q_v[3]) begin
      n_fail++;
      $display("FAIL R3 out_valid actual %0b expected %0b", out_valid, q_v[3]);
    end
    if (q_v[3]) begin
      n_chk++;
      if (out_pix !== q_p[3] || out_sof !== q_s[3]) begin
        n_fail++;
        $display("FAIL %s pixel actual %h sof %0b expected %h sof %0b",
                 q_t[3], out_pix, out_sof, q_p[3], q_s[3]);
      end
    end
  endtask

  task automatic check_mode(int exp, string tag);
    n_chk++;
    if (active_mode !== 2'(exp)) begin
      n_fail++;
      $display("FAIL %s active_mode actual %0d expected %0d", tag, active_mode, exp);
    end
  endtask

  // One cycle: check due output, drive inputs, update the model.
  task automatic step(bit v, bit s, logic [PW-1:0] p, bit we, logic [2:0] a,
                      logic [31:0] d, string tag);
    int eff;
    logic [PW-1:0] e;
    check_out();
    in_valid = v; in_sof = s; in_pix = p;
    cfg_we = we; cfg_addr = a; cfg_wdata = d;
    eff = (v && s) ? m_pend : m_act;
    if (v && s) m_act = m_pend;
    e = p;
    if (eff != 0)
      for (int r = 0; r < 3; r++) e[r*PIX_W +: PIX_W] = calc(p, eff - 1, r);
    if (we) begin
      if (a < 6) begin
        int tb = (m_act == 1) ? 1 : 0;
        mb[tb][2*a]   = d[15:0];
        mb[tb][2*a+1] = d[31:16];
      end else if (a == 7 && d[1:0] != 2'd3) begin
        m_pend = int'(d[1:0]);
      end
    end
    @(posedge clk);
    q_v[3] = q_v[2]; q_s[3] = q_s[2]; q_p[3] = q_p[2]; q_t[3] = q_t[2];
    q_v[2] = q_v[1]; q_s[2] = q_s[1]; q_p[2] = q_p[1]; q_t[2] = q_t[1];
    q_v[1] = v;      q_s[1] = v && s; q_p[1] = e;      q_t[1] = tag;
    @(negedge clk);
  endtask

  task automatic pix(bit v, bit s, logic [PW-1:0] p, string tag);
    step(v, s, p, 1'b0, 3'd0, 32'd0, tag);
  endtask

  task automatic hw(logic [2:0] a, logic [31:0] d);
    step(1'b0, 1'b0, '0, 1'b1, a, d, "R7");
  endtask

  function automatic logic [PW-1:0] rpix();
    return PW'({$urandom, $urandom});
  endfunction

  function automatic logic [15:0] rgain();
    return 16'($urandom_range(0, 16383) - 8192);
  endfunction

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd20251));
    for (int i = 1; i <= 3; i++) begin q_v[i] = 0; q_s[i] = 0; q_p[i] = '0; q_t[i] = ""; end
    for (int b = 0; b < 2; b++) for (int i = 0; i < 12; i++) mb[b][i] = '0;
    repeat (5) @(negedge clk);
    // R1: reset state
    n_chk++;
    if (out_valid !== 1'b0) begin n_fail++; $display("FAIL R1 out_valid actual %0b expected 0", out_valid); end
    check_mode(0, "R1");
    rst = 1'b0;
    @(negedge clk);

    // R1/R2: frame start with no mode write stays bypass
    pix(1, 1, rpix(), "R1");
    for (int i = 0; i < 8; i++) pix(1, 0, rpix(), "R2");
    pix(0, 0, '0, "R3");
    pix(1, 0, {10'd1023, 10'd0, 10'd512}, "R2");
    pix(0, 0, '0, "R3");
    check_mode(0, "R1");

    // R6/R7: identity into bank A (idle while bypass)
    hw(3'd0, {16'h0000, 16'h2000});
    hw(3'd1, 32'h0);
    hw(3'd2, {16'h2000, 16'h0000});
    hw(3'd3, 32'h0);
    hw(3'd4, 32'h0);
    hw(3'd5, {16'h0000, 16'h2000});
    hw(3'd7, 32'd1);
    pix(1, 0, rpix(), "R10");
    check_mode(0, "R10");
    pix(1, 1, {10'd1023, 10'd1023, 10'd1023}, "R6");
    check_mode(1, "R10");
    pix(1, 0, '0, "R6");
    for (int i = 0; i < 10; i++) pix(1, 0, rpix(), "R6");

    // R8: program bank B mid-frame; frame A unaffected
    for (int k = 0; k < 6; k++) hw(3'(k), {rgain(), rgain()});
    hw(3'd7, 32'd2);
    for (int i = 0; i < 6; i++) pix(1, 0, rpix(), "R8");
    check_mode(1, "R10");
    pix(1, 1, rpix(), "R4");
    check_mode(2, "R10");
    for (int i = 0; i < 12; i++) pix(1, 0, rpix(), "R4");

    // R5: saturation matrix in bank A
    hw(3'd0, 32'h7FFF7FFF);
    hw(3'd1, 32'h7FFF7FFF);
    hw(3'd2, 32'h80008000);
    hw(3'd3, 32'h80008000);
    hw(3'd4, {16'h0000, 16'h2000});
    hw(3'd5, 32'h0);
    hw(3'd7, 32'd1);
    pix(1, 1, '0, "R5");
    pix(1, 0, {10'd1023, 10'd1023, 10'd1023}, "R5");
    pix(1, 0, {10'd0, 10'd0, 10'd7}, "R5");
    for (int i = 0; i < 5; i++) pix(1, 0, rpix(), "R5");

    // R9: value 3 ignored
    hw(3'd7, 32'd3);
    pix(1, 1, rpix(), "R9");
    check_mode(1, "R9");
    pix(1, 0, {10'd1023, 10'd1023, 10'd1023}, "R9");

    // R2: back to bypass at next frame
    hw(3'd7, 32'd0);
    pix(1, 0, rpix(), "R10");
    pix(1, 1, rpix(), "R2");
    check_mode(0, "R2");
    for (int i = 0; i < 4; i++) pix(1, 0, rpix(), "R2");

    // R4: random stream with host traffic between pixels
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 15) == 0) begin
        if ($urandom_range(0, 3) == 0) hw(3'd7, 32'($urandom_range(0, 3)));
        else hw(3'($urandom_range(0, 5)), {rgain(), rgain()});
      end else begin
        pix($urandom_range(0, 3) != 0, $urandom_range(0, 63) == 0, rpix(), "R4");
      end
    end
    for (int i = 0; i < 4; i++) pix(0, 0, '0, "R3");
    summary();
  end
endmodule